// File: doc/BRIEF.md
# Operand-Coherent Bus Arbiter

This block decides which of four bus masters owns a shared system bus: an external requester, two DMA channels and the CPU. Ownership changes only at operand boundaries. A master that has started an operand keeps the bus through every bus cycle of that operand, even when the operand is split across several narrow-port cycles. A locked read-modify-write sequence is never broken up.

Each master drives a request line and two per-cycle flags. The "final" flag marks the bus cycle that completes the master's current operand. The "locked" flag marks a cycle that belongs to an indivisible sequence. A shared strobe reports that the current bus cycle has finished.

The master itself decides where its operand boundaries fall. A single-address DMA transfer keeps the final flag low until the whole transfer is done. A dual-address transfer raises it after the read and again after the write. A transfer between ports of different widths raises it after each narrow access. A multi-operand operation raises it after each operand. The two DMA channels are ranked by programmable levels. When no master requests the bus, it is parked on the CPU.

Top module: `opc_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, `gnt_o` is all zeros. After `rst_n` is released, `gnt_o` stays zero for SYNC_STAGES rising edges and shows the first winner after the following edge.
- R2: At an arbitration point the fixed order is: external (bit 0) first, then DMA (bits 1 and 2), then CPU (bit 3) last. All master vectors use this bit order.
- R3: When both DMA channels request, the channel with the numerically larger level wins. With equal levels, channel 1 (bit 1) wins and `cfg_err_o` is high. `cfg_err_o` is low whenever the levels differ.
- R4: The owner keeps the grant across any number of completed bus cycles whose final flag is low, even while a higher-priority master requests.
- R5: A grant change takes effect on the rising edge at which `cyc_done_i` is sampled high together with the owner's final flag high and its locked flag low. The new grant is visible right after that edge.
- R6: While the owner's locked flag is high, the grant does not change, even when a cycle completes with its final flag set.
- R7: Every completed cycle with the final flag set is an arbitration point, so a split transfer (dual-address read then write) can lose the bus between its parts.
- R8: When no master requests, the bus parks on the CPU. An owner that is not requesting and has no operand open gives up the bus at the next edge.
- R9: After the reset window `gnt_o` is one-hot. `busy_o` is high while the owner requests or has an operand open, and low after an operand ends with no owner request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Bus requests: bit0 external, bit1 DMA ch1, bit2 DMA ch2, bit3 CPU |
| last_i | input | 4 | Per-master flag: the current cycle ends the operand |
| lock_i | input | 4 | Per-master flag: the current cycle is inside a locked sequence |
| cyc_done_i | input | 1 | The current bus cycle completes at this edge |
| dma1_lvl_i | input | LVL_W | Arbitration level of DMA channel 1 |
| dma2_lvl_i | input | LVL_W | Arbitration level of DMA channel 2 |
| gnt_o | output | 4 | One-hot grant, same bit order as req_i |
| busy_o | output | 1 | Owner is requesting or has an operand open |
| cfg_err_o | output | 1 | DMA levels are equal (configuration error) |

## Verification
The bench builds the block with LVL_W = 3 and two reset synchronizer stages. Three-bit levels let it program equal levels (the tie-break and error flag) and both orderings of unequal levels. The two-stage synchronizer makes the reset-release latency a short, exact window that the bench counts edge by edge. With these values, a four-cycle operand with ongoing higher-priority pressure, a locked sequence that ends on a final cycle, and a dual-address split all fit in a few cycles each.

// File: rtl/opc_arb_pkg.sv
package opc_arb_pkg;
  localparam int NUM_M = 4;
  localparam int IDX_W = $clog2(NUM_M);
  localparam int M_EXT  = 0;
  localparam int M_DMA1 = 1;
  localparam int M_DMA2 = 2;
  localparam int M_CPU  = 3;
  typedef logic [NUM_M-1:0] mvec_t;
  typedef logic [IDX_W-1:0] midx_t;
endpackage

// File: rtl/opc_rst_sync.sv
module opc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shreg_q <= '0;
    else         shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shreg_q[STAGES-1];
endmodule

// File: rtl/opc_dma_rank.sv
module opc_dma_rank #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] lvl_a_i,
  input  logic [LVL_W-1:0] lvl_b_i,
  output logic             b_first_o,
  output logic             tie_o
);
  // Channel b only wins on a strictly larger level; ties go to channel a.
  always_comb begin
    b_first_o = (lvl_b_i > lvl_a_i);
    tie_o     = (lvl_b_i == lvl_a_i);
  end
endmodule

// File: rtl/opc_win_sel.sv
module opc_win_sel
  import opc_arb_pkg::*;
(
  input  mvec_t req_i,
  input  logic  ch2_first_i,
  output mvec_t win_o
);
  midx_t order [NUM_M];
  logic  found;

  always_comb begin
    order[0] = midx_t'(M_EXT);
    order[1] = ch2_first_i ? midx_t'(M_DMA2) : midx_t'(M_DMA1);
    order[2] = ch2_first_i ? midx_t'(M_DMA1) : midx_t'(M_DMA2);
    order[3] = midx_t'(M_CPU);
    win_o = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_M; k++) begin
      // The CPU slot is always eligible: it is the parking owner.
      if (!found && (req_i[order[k]] || (order[k] == midx_t'(M_CPU)))) begin
        win_o[order[k]] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/opc_own_ctrl.sv
module opc_own_ctrl
  import opc_arb_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  mvec_t req_i,
  input  mvec_t last_i,
  input  mvec_t lock_i,
  input  logic  cyc_done_i,
  input  mvec_t win_i,
  output mvec_t gnt_o,
  output logic  busy_o
);
  mvec_t gnt_q, gnt_d;
  logic  busy_q, busy_d;
  logic  own_req, own_last, own_lock;
  logic  end_op, idle_yield, arb_en;

  always_comb begin
    own_req    = |(req_i  & gnt_q);
    own_last   = |(last_i & gnt_q);
    own_lock   = |(lock_i & gnt_q);
    end_op     = cyc_done_i & own_last & ~own_lock;
    idle_yield = ~busy_q & ~own_req & ~own_lock;
    arb_en     = end_op | idle_yield;
    gnt_d      = win_i;
    if (end_op)       busy_d = 1'b0;
    else if (own_req) busy_d = 1'b1;
    else              busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     gnt_q <= '0;
    else if (arb_en) gnt_q <= gnt_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign gnt_o  = gnt_q;
  assign busy_o = busy_q | own_req;
endmodule

// File: rtl/opc_bus_arbiter.sv
module opc_bus_arbiter #(
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       req_i,
  input  logic [3:0]       last_i,
  input  logic [3:0]       lock_i,
  input  logic             cyc_done_i,
  input  logic [LVL_W-1:0] dma1_lvl_i,
  input  logic [LVL_W-1:0] dma2_lvl_i,
  output logic [3:0]       gnt_o,
  output logic             busy_o,
  output logic             cfg_err_o
);
  import opc_arb_pkg::*;

  logic  srst_n;
  logic  ch2_first;
  mvec_t win;

  opc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  opc_dma_rank #(.LVL_W(LVL_W)) u_rank (
    .lvl_a_i(dma1_lvl_i), .lvl_b_i(dma2_lvl_i),
    .b_first_o(ch2_first), .tie_o(cfg_err_o)
  );

  opc_win_sel u_sel (
    .req_i(req_i), .ch2_first_i(ch2_first), .win_o(win)
  );

  opc_own_ctrl u_own (
    .clk(clk), .srst_n(srst_n), .req_i(req_i), .last_i(last_i),
    .lock_i(lock_i), .cyc_done_i(cyc_done_i), .win_i(win),
    .gnt_o(gnt_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/opc_bus_arbiter_chk.sv
module opc_bus_arbiter_chk #(
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       req_i,
  input logic [3:0]       last_i,
  input logic [3:0]       lock_i,
  input logic             cyc_done_i,
  input logic [LVL_W-1:0] dma1_lvl_i,
  input logic [LVL_W-1:0] dma2_lvl_i,
  input logic [3:0]       gnt_o,
  input logic             busy_o,
  input logic             cfg_err_o
);
  localparam int CW = $clog2(SYNC_STAGES + 2) + 1;
  logic [CW-1:0] up_cnt;
  logic          owner_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              up_cnt <= '0;
    else if (up_cnt != CW'(SYNC_STAGES + 1)) up_cnt <= up_cnt + 1'b1;
  end

  assign owner_end = cyc_done_i && ((gnt_o & last_i & ~lock_i) != 4'b0);

  p_no_gnt_reset_r1: assert property (@(posedge clk) !rst_n |-> gnt_o == 4'b0);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == CW'(SYNC_STAGES + 1)) |-> $countones(gnt_o) == 1);

  p_ext_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_end && req_i[0]) |=> gnt_o[0]);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt_o & req_i) != 4'b0) && !owner_end) |=> $stable(gnt_o));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & lock_i) != 4'b0) |=> $stable(gnt_o));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & req_i) != 4'b0) |-> busy_o);
endmodule

bind opc_bus_arbiter opc_bus_arbiter_chk #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .last_i(last_i), .lock_i(lock_i),
  .cyc_done_i(cyc_done_i), .dma1_lvl_i(dma1_lvl_i), .dma2_lvl_i(dma2_lvl_i),
  .gnt_o(gnt_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o)
);

// File: tb/opc_bus_arbiter_tb_top.sv
module opc_bus_arbiter_tb_top;
  localparam int LVL_W = 3;
  localparam logic [3:0] G_EXT = 4'b0001, G_D1 = 4'b0010, G_D2 = 4'b0100, G_CPU = 4'b1000;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] req, last, lock;
  logic done;
  logic [LVL_W-1:0] lvl1, lvl2;
  logic [3:0] gnt;
  logic busy, cfg_err;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  opc_bus_arbiter #(.LVL_W(LVL_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .last_i(last), .lock_i(lock),
    .cyc_done_i(done), .dma1_lvl_i(lvl1), .dma2_lvl_i(lvl2),
    .gnt_o(gnt), .busy_o(busy), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    req = '0; last = '0; lock = '0; done = 1'b0;
  endtask

  task automatic do_reset(input bit verify);
    @(negedge clk);
    rst_n = 1'b0;
    idle_in();
    step();
    if (verify) begin
      req = 4'b0111;
      #1;
      chk("R1 no grant in reset", gnt, 4'b0);
      req = '0;
    end
    rst_n = 1'b1;
    step();
    if (verify) chk("R1 sync edge 1", gnt, 4'b0);
    step();
    if (verify) chk("R1 sync edge 2", gnt, 4'b0);
    step();
    chk("R8 park after reset", gnt, G_CPU);
    if (verify) chk("R9 busy idle", busy, 1'b0);
  endtask

  task automatic t_priority();
    do_reset(0);
    lvl1 = 3'd5; lvl2 = 3'd2;
    req = 4'b0111; step();
    chk("R2 ext over DMA", gnt, G_EXT);
    chk("R9 busy owner req", busy, 1'b1);
    req = 4'b0110; done = 1'b1; last = G_EXT; step();
    chk("R3 higher DMA level wins", gnt, G_D1);
    done = 1'b0; last = '0; step();
    chk("R4 DMA1 held", gnt, G_D1);
    req = 4'b1100; done = 1'b1; last = G_D1; step();
    chk("R2 DMA over CPU", gnt, G_D2);
    idle_in();
  endtask

  task automatic t_tie();
    do_reset(0);
    lvl1 = 3'd3; lvl2 = 3'd3; #1;
    chk("R3 equal levels flag", cfg_err, 1'b1);
    req = 4'b0110; step();
    chk("R3 tie goes to ch1", gnt, G_D1);
    lvl2 = 3'd7; done = 1'b1; last = G_D1; step();
    chk("R3 ch2 larger level wins", gnt, G_D2);
    chk("R3 flag clear on distinct", cfg_err, 1'b0);
    idle_in();
  endtask

  task automatic t_hold();
    do_reset(0);
    lvl1 = 3'd1; lvl2 = 3'd2;
    req = 4'b0010; step();
    chk("R4 DMA1 granted", gnt, G_D1);
    req = 4'b0011;
    for (int i = 0; i < 3; i++) begin
      done = 1'b1; last = '0; step();
      chk("R4 mid-operand hold", gnt, G_D1);
      done = 1'b0; step();
    end
    done = 1'b1; last = G_D1; step();
    chk("R5 switch after final cycle", gnt, G_EXT);
    idle_in();
  endtask

  task automatic t_lock();
    do_reset(0);
    req = 4'b1000; step();
    chk("R6 CPU owns", gnt, G_CPU);
    req = 4'b1010; lock = G_CPU; last = G_CPU; done = 1'b1; step();
    chk("R6 locked final cycle holds", gnt, G_CPU);
    step();
    chk("R6 locked hold again", gnt, G_CPU);
    lock = '0; step();
    chk("R6 release after unlock", gnt, G_D1);
    idle_in();
  endtask

  task automatic t_split();
    do_reset(0);
    lvl1 = 3'd1; lvl2 = 3'd4;
    req = 4'b0100; step();
    chk("R7 DMA2 granted", gnt, G_D2);
    req = 4'b0110; done = 1'b1; last = G_D2; step();
    chk("R7 read boundary keeps higher level", gnt, G_D2);
    req = 4'b0111; step();
    chk("R7 ext takes bus between read and write", gnt, G_EXT);
    idle_in();
  endtask

  task automatic t_park();
    do_reset(0);
    req = 4'b0010; step();
    chk("R8 DMA1 granted", gnt, G_D1);
    req = '0; done = 1'b1; last = G_D1; step();
    chk("R8 park on CPU", gnt, G_CPU);
    chk("R9 busy low after end", busy, 1'b0);
    idle_in();
    req = 4'b0010; step();
    chk("R8 idle CPU yields", gnt, G_D1);
    req = 4'b0001; step();
    chk("R8 unused grant yields", gnt, G_EXT);
    idle_in();
  endtask

  initial begin
    rst_n = 1'b0;
    idle_in();
    lvl1 = 3'd1; lvl2 = 3'd2;
    do_reset(1);
    t_priority();
    t_tie();
    t_hold();
    t_lock();
    t_split();
    t_park();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule